// File: doc/BRIEF.md
# Interrupt Source Masking and Routing

This block gathers a vector of level-sensitive hardware interrupt lines and a software trigger register of the same width. It merges them per bit into one set of sources and sends each source to either a fast path or a normal path. A per-bit route register chooses the path. An enable register qualifies only the normal path. Sources sent to the fast path are never masked, and any of them raises a registered fast interrupt line.

A simple word-addressed register bus writes the enable, software trigger, route and protection registers. Enable and software trigger each have a set word and a separate clear word, so software can change single bits without a read-modify-write.

The same bus reads back three status words: merged sources, normal-path pending and fast-path pending. The normal-path pending vector is also brought out as a port. A separate priority block gates it against the current level; that gating is not done here.

Top module: `intr_steer`

## Requirements
- R1: The merged source word is the bitwise OR of the synchronised hardware lines and the software trigger register. It reads at word offset 2.
- R2: The normal-path word is merged AND enable AND NOT route. It reads at word offset 0 and drives `norm_status`. No bit is ever set in both the normal-path and fast-path words.
- R3: The fast-path word is merged AND route, whatever the enable bits hold. It reads at word offset 1.
- R4: `fast_irq` is a register. It is high in the cycle after any cycle in which the fast-path word is non-zero, and low otherwise.
- R5: A write to offset 4 ORs the data into the enable register. A read of offset 4 returns the enable register. No other offset changes it, except offset 5.
- R6: A write to offset 5 clears each enable bit that is written as one. A read of offset 5 returns zero.
- R7: A write to offset 6 sets each software trigger bit that is written as one. A read of offset 6 returns the register.
- R8: A write to offset 7 clears each software trigger bit that is written as one. A read of offset 7 returns zero.
- R9: A write to offset 3 loads the route register with the data, where a 1 sends a source to the fast path. A read of offset 3 returns the route register.
- R10: A write to offset 8 stores only data bit 0 as the protection flag. A read of offset 8 returns the flag in bit 0 and zeros in the upper bits.
- R11: Writes to offsets 0, 1 and 2 and to offsets 9 to 15 change no register. Reads of offsets 9 to 15 return zero.
- R12: A change on a hardware line reaches the status words exactly two clock edges later. It does not show after one edge.
- R13: Reset clears enable, software trigger, route and protection, and drives `fast_irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_irq | input | W | Hardware interrupt lines, level-sensitive, asynchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr`, combinational |
| norm_status | output | W | Normal-path pending sources |
| fast_irq | output | 1 | Fast interrupt request, registered |

## Verification
Software trigger clearing and hardware arrival can fall in the same cycle on the same source bit. The bench makes this happen by writing the software-clear word on the same edge on which a hardware line for that bit rises. The merged word must then drop the bit for one cycle, while the synchroniser is still filling, and show it again on the second edge, with the software register read back as zero. A second overlap comes from rewriting the route register while sources are pending. Here the bench checks that a source moves between the normal and fast words in a single step and never appears in both.

// File: rtl/intr_steer_pkg.sv
package intr_steer_pkg;

  localparam int OFS_W = 4;

  typedef enum logic [OFS_W-1:0] {
    OFS_NORM   = 4'd0,
    OFS_FAST   = 4'd1,
    OFS_RAW    = 4'd2,
    OFS_ROUTE  = 4'd3,
    OFS_EN_SET = 4'd4,
    OFS_EN_CLR = 4'd5,
    OFS_SW_SET = 4'd6,
    OFS_SW_CLR = 4'd7,
    OFS_PROT   = 4'd8
  } ofs_e;

endpackage

// File: rtl/intr_steer_sync.sv
module intr_steer_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[LAST];

endmodule

// File: rtl/intr_steer_regs.sv
module intr_steer_regs
  import intr_steer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     en_q,
  output logic [W-1:0]     sw_q,
  output logic [W-1:0]     route_q,
  output logic             prot_q
);

  function automatic logic [W-1:0] f_set(input logic [W-1:0] cur, input logic [W-1:0] val);
    return cur | val;
  endfunction

  function automatic logic [W-1:0] f_clr(input logic [W-1:0] cur, input logic [W-1:0] val);
    return cur & ~val;
  endfunction

  logic hit_en_set, hit_en_clr, hit_sw_set, hit_sw_clr, hit_route, hit_prot;

  assign hit_en_set = wr_en && (wr_ofs == OFS_EN_SET);
  assign hit_en_clr = wr_en && (wr_ofs == OFS_EN_CLR);
  assign hit_sw_set = wr_en && (wr_ofs == OFS_SW_SET);
  assign hit_sw_clr = wr_en && (wr_ofs == OFS_SW_CLR);
  assign hit_route  = wr_en && (wr_ofs == OFS_ROUTE);
  assign hit_prot   = wr_en && (wr_ofs == OFS_PROT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (hit_en_set) begin
      en_q <= f_set(en_q, wr_data);
    end else if (hit_en_clr) begin
      en_q <= f_clr(en_q, wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
    end else if (hit_sw_set) begin
      sw_q <= f_set(sw_q, wr_data);
    end else if (hit_sw_clr) begin
      sw_q <= f_clr(sw_q, wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         route_q <= '0;
    else if (hit_route) route_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prot_q <= 1'b0;
    else if (hit_prot) prot_q <= wr_data[0];
  end

endmodule

// File: rtl/intr_steer_status.sv
module intr_steer_status
  import intr_steer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     hw_s,
  input  logic [W-1:0]     en,
  input  logic [W-1:0]     sw,
  input  logic [W-1:0]     route,
  input  logic             prot,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [W-1:0]     raw,
  output logic [W-1:0]     norm,
  output logic [W-1:0]     fast,
  output logic [W-1:0]     rdata
);

  function automatic logic [W-1:0] f_merge(input logic [W-1:0] h, input logic [W-1:0] s);
    return h | s;
  endfunction

  function automatic logic [W-1:0] f_norm(input logic [W-1:0] r, input logic [W-1:0] e,
                                          input logic [W-1:0] rt);
    return r & e & ~rt;
  endfunction

  function automatic logic [W-1:0] f_fast(input logic [W-1:0] r, input logic [W-1:0] rt);
    return r & rt;
  endfunction

  assign raw  = f_merge(hw_s, sw);
  assign norm = f_norm(raw, en, route);
  assign fast = f_fast(raw, route);

  always_comb begin
    rdata = '0;
    case (rd_ofs)
      OFS_NORM:   rdata = norm;
      OFS_FAST:   rdata = fast;
      OFS_RAW:    rdata = raw;
      OFS_ROUTE:  rdata = route;
      OFS_EN_SET: rdata = en;
      OFS_SW_SET: rdata = sw;
      OFS_PROT:   rdata = {{(W-1){1'b0}}, prot};
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/intr_steer.sv
module intr_steer
  import intr_steer_pkg::*;
#(
  parameter int W          = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     hw_irq,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  output logic [W-1:0]     norm_status,
  output logic             fast_irq
);

  logic           wr_en;
  logic [W-1:0]   hw_s;
  logic [W-1:0]   en_q, sw_q, route_q;
  logic           prot_q;
  logic [W-1:0]   raw_w, norm_w, fast_w;
  logic           fast_any;

  assign wr_en = bus_sel & bus_wr;

  intr_steer_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (hw_irq),
    .q_sync  (hw_s)
  );

  intr_steer_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ofs  (bus_addr),
    .wr_data (bus_wdata),
    .en_q    (en_q),
    .sw_q    (sw_q),
    .route_q (route_q),
    .prot_q  (prot_q)
  );

  intr_steer_status #(.W(W)) u_stat (
    .hw_s   (hw_s),
    .en     (en_q),
    .sw     (sw_q),
    .route  (route_q),
    .prot   (prot_q),
    .rd_ofs (bus_addr),
    .raw    (raw_w),
    .norm   (norm_w),
    .fast   (fast_w),
    .rdata  (bus_rdata)
  );

  assign fast_any    = |fast_w;
  assign norm_status = norm_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_irq <= 1'b0;
    else        fast_irq <= fast_any;
  end

endmodule

// File: rtl/intr_steer_chk.sv
module intr_steer_chk
  import intr_steer_pkg::*;
#(
  parameter int W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [OFS_W-1:0] wr_ofs,
  input logic [W-1:0]     wr_data,
  input logic [W-1:0]     en_q,
  input logic [W-1:0]     sw_q,
  input logic [W-1:0]     route_q,
  input logic             prot_q,
  input logic [W-1:0]     raw_w,
  input logic [W-1:0]     norm_w,
  input logic [W-1:0]     fast_w,
  input logic             fast_irq
);

  p_fast_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_w != '0) |=> fast_irq);

  p_fast_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_w == '0) |=> !fast_irq);

  p_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_w & fast_w) == '0);

  p_fast_in_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_w & ~raw_w) == '0);

  p_sw_in_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q & ~raw_w) == '0);

  p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_EN_SET) |=> (en_q == ($past(en_q) | $past(wr_data))));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_ofs == OFS_EN_SET || wr_ofs == OFS_EN_CLR)) |=> $stable(en_q));

  p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_EN_CLR) |=> ((en_q & $past(wr_data)) == '0));

  p_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_SW_SET) |=> ((sw_q & $past(wr_data)) == $past(wr_data)));

  p_sw_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_SW_CLR) |=> ((sw_q & $past(wr_data)) == '0));

  p_route_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_ROUTE) |=> (route_q == $past(wr_data)));

  p_prot_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_PROT) |=> (prot_q == $past(wr_data[0])));

  p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ofs <= OFS_RAW || wr_ofs > OFS_PROT))
      |=> ($stable(sw_q) && $stable(route_q) && $stable(prot_q)));

endmodule

bind intr_steer intr_steer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_ofs   (bus_addr),
  .wr_data  (bus_wdata),
  .en_q     (en_q),
  .sw_q     (sw_q),
  .route_q  (route_q),
  .prot_q   (prot_q),
  .raw_w    (raw_w),
  .norm_w   (norm_w),
  .fast_w   (fast_w),
  .fast_irq (fast_irq)
);

// File: tb/test_intr_steer.sv
`timescale 1ns/1ps
module test_intr_steer;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] hw_irq = '0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] norm_status;
  logic         fast_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [W-1:0] m_en = '0, m_sw = '0, m_rt = '0, m_hw = '0;
  logic         m_prot = 1'b0;

  always #5 clk = ~clk;

  intr_steer #(.W(W)) i_intr_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_irq      (hw_irq),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .norm_status (norm_status),
    .fast_irq    (fast_irq)
  );

  function automatic logic [W-1:0] mdl_raw();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (m_hw[i] === 1'b1) || (m_sw[i] === 1'b1);
    return r;
  endfunction

  function automatic logic [W-1:0] mdl_norm();
    logic [W-1:0] r = mdl_raw();
    logic [W-1:0] o;
    for (int i = 0; i < W; i++) o[i] = r[i] && m_en[i] && !m_rt[i];
    return o;
  endfunction

  function automatic logic [W-1:0] mdl_fast();
    logic [W-1:0] r = mdl_raw();
    logic [W-1:0] o;
    for (int i = 0; i < W; i++) o[i] = r[i] && m_rt[i];
    return o;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    @(negedge clk);
    for (int a = 0; a <= 8; a++) begin
      bus_read(a[3:0], d);
      check("R13 reset read", d, '0);
    end
    check("R13 fast_irq after reset", {31'b0, fast_irq}, '0);
    check("R2 norm_status after reset", norm_status, '0);
  endtask

  task automatic t_enable();
    logic [W-1:0] d;
    bus_write(4'd4, 32'h0000_00F0); m_en |= 32'h0000_00F0;
    bus_write(4'd4, 32'h0000_0F00); m_en |= 32'h0000_0F00;
    bus_read(4'd4, d); check("R5 enable set accumulates", d, 32'h0000_0FF0);
    bus_write(4'd5, 32'h0000_0030); m_en &= ~32'h0000_0030;
    bus_read(4'd4, d); check("R6 enable clear", d, 32'h0000_0FC0);
    bus_read(4'd5, d); check("R6 clear word reads zero", d, '0);
  endtask

  task automatic t_soft();
    logic [W-1:0] d;
    bus_write(4'd6, 32'h0000_0005); m_sw |= 32'h5;
    bus_write(4'd6, 32'h0000_00A0); m_sw |= 32'hA0;
    bus_read(4'd6, d); check("R7 software set", d, 32'h0000_00A5);
    bus_write(4'd7, 32'h0000_0021); m_sw &= ~32'h21;
    bus_read(4'd6, d); check("R8 software clear", d, 32'h0000_0084);
    bus_read(4'd7, d); check("R8 clear word reads zero", d, '0);
    bus_read(4'd2, d); check("R1 merged word", d, mdl_raw());
    bus_read(4'd0, d); check("R2 normal word", d, mdl_norm());
    check("R2 norm_status port", norm_status, 32'h0000_0080);
  endtask

  task automatic t_route();
    logic [W-1:0] d;
    bus_write(4'd3, 32'h0000_0004); m_rt = 32'h4;
    bus_read(4'd3, d); check("R9 route readback", d, 32'h0000_0004);
    bus_read(4'd1, d); check("R3 fast word ignores enable", d, 32'h0000_0004);
    check("R4 fast_irq not yet", {31'b0, fast_irq}, '0);
    @(negedge clk);
    check("R4 fast_irq one edge later", {31'b0, fast_irq}, 32'h1);
    bus_write(4'd3, 32'h0000_0080); m_rt = 32'h80;
    bus_read(4'd1, d); check("R3 fast word after reroute", d, mdl_fast());
    bus_read(4'd0, d); check("R2 source left normal word", d, mdl_normal_or(d));
    check("R2 normal and fast disjoint", norm_status & mdl_fast(), '0);
    bus_write(4'd3, 32'h0); m_rt = '0;
    @(negedge clk);
    check("R4 fast_irq drops", {31'b0, fast_irq}, '0);
  endtask

  function automatic logic [W-1:0] mdl_normal_or(input logic [W-1:0] unused_d);
    return mdl_norm() | (unused_d & 32'h0);
  endfunction

  task automatic t_hw();
    logic [W-1:0] d;
    bus_write(4'd7, 32'hFFFF_FFFF); m_sw = '0;
    @(negedge clk);
    hw_irq = 32'h8000_0040;
    @(negedge clk);
    bus_read(4'd2, d); check("R12 not visible after one edge", d, 32'h0);
    @(negedge clk);
    m_hw = hw_irq;
    bus_read(4'd2, d); check("R12 visible after two edges", d, 32'h8000_0040);
    bus_read(4'd0, d); check("R1 hardware into normal word", d, mdl_norm());
  endtask

  task automatic t_collide();
    logic [W-1:0] d;
    bus_write(4'd6, 32'h0000_0200); m_sw |= 32'h200;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h0000_0200;
    hw_irq = hw_irq | 32'h0000_0200;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    m_sw &= ~32'h200;
    bus_read(4'd2, d); check("R8 merged drops while sync fills", d & 32'h200, 32'h0);
    @(negedge clk);
    m_hw = hw_irq;
    bus_read(4'd2, d); check("R1 hardware holds source after clear", d, mdl_raw());
    bus_read(4'd6, d); check("R8 software bit stays clear", d, '0);
  endtask

  task automatic t_prot();
    logic [W-1:0] d;
    bus_write(4'd8, 32'hFFFF_FFFF); m_prot = 1'b1;
    bus_read(4'd8, d); check("R10 only bit 0 stored", d, 32'h1);
    bus_write(4'd8, 32'h0000_0002); m_prot = 1'b0;
    bus_read(4'd8, d); check("R10 bit 1 ignored", d, 32'h0);
  endtask

  task automatic t_ignored();
    logic [W-1:0] d;
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_write(4'd1, 32'hFFFF_FFFF);
    bus_write(4'd2, 32'hFFFF_FFFF);
    for (int a = 9; a < 16; a++) bus_write(a[3:0], 32'hFFFF_FFFF);
    bus_read(4'd4, d); check("R11 enable untouched", d, m_en);
    bus_read(4'd6, d); check("R11 software untouched", d, m_sw);
    bus_read(4'd3, d); check("R11 route untouched", d, m_rt);
    bus_read(4'd8, d); check("R11 protection untouched", d, {31'b0, m_prot});
    bus_read(4'd0, d); check("R11 normal word unchanged", d, mdl_norm());
    for (int a = 9; a < 16; a++) begin
      bus_read(a[3:0], d); check("R11 unused offset reads zero", d, '0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_soft();
    t_route();
    t_hw();
    t_collide();
    t_prot();
    t_ignored();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule